// File: doc/BRIEF.md
# Register-Mapped Parallel I/O Port

This block gives a host a parameterized group of 1 to 32 general-purpose pins through four word registers on a simple memory-mapped slave. The register set covers the output value, the per-pin direction, an interrupt enable mask and a sticky record of input transitions. A build-time mode makes the port input-only, output-only or bidirectional. In bidirectional mode each pin has an output enable that an external tristate buffer uses. Reading the data register returns the synchronized level on the input pins and never the value last written for the outputs.

Input pins pass through a two-stage synchronizer. A transition is detected by comparing the synchronized value with its value one clock earlier. The edge kind (rising, falling or either) is fixed at build time. Detected transitions set bits in the capture register, and those bits stay set until the host clears them. A single interrupt line is formed from the capture bits and the mask. A build variant forms it from the synchronized input levels instead.

The slave takes a request on every clock in which `bus_sel` is high, so it never applies back-pressure. A write takes effect on that clock edge. Read data appears on `bus_rdata` one clock after the request and is held until the next read.

Top module: `parport_top`

## Requirements
- R1: After reset, the output value, direction, mask and capture registers are all zero, so `pins_out`, `pins_oe` and `irq` are low.
- R2: A read of the data register (offset 0) returns the input pins after two synchronizer clocks, zero-extended to 32 bits, one clock after the request.
- R3: A write to offset 0 sets `pins_out` on the following clock, and a later read of offset 0 returns the inputs rather than that written value.
- R4: In bidirectional mode, bit n of the direction register (offset 1) drives `pins_oe[n]` (1 = drive). Input-only builds keep `pins_oe` and `pins_out` at zero, and output-only builds keep `pins_oe` at all ones.
- R5: An input transition of the build-time kind sets the matching capture bit (offset 3). In a rising-only build, a falling transition sets nothing.
- R6: A capture bit stays set until the host writes a 1 to that bit of offset 3. Writing 0 to the bit leaves it set.
- R7: If a new transition and a clear of the same capture bit land on the same clock, the bit stays set.
- R8: In edge-interrupt builds, `irq` is high exactly when some capture bit and the matching mask bit (offset 2) are both 1.
- R9: In level-interrupt builds, `irq` is high exactly when some synchronized input bit and its mask bit are both 1.
- R10: Reads of a register that the build does not implement (for example, direction in an input-only build) return zero.
- R11: Register bits above the port width read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Request strobe; accepted every cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word offset: 0 data, 1 direction, 2 mask, 3 capture |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after a read request |
| pins_in | input | WIDTH | Asynchronous input pins |
| pins_out | output | WIDTH | Output pin values |
| pins_oe | output | WIDTH | Per-pin output enable for tristate control |
| irq | output | 1 | Interrupt request |

## Verification
A capture bit stuck high shows on the next read of offset 3 and, if its mask bit is set, raises `irq` at once. A bit that drops early shows as `irq` falling with no clear having been written. A synchronizer or edge register with the wrong delay moves the capture bit, and with it `irq`, away from the third clock after a pin change, which is where the bench samples. A direction or output register that changes without a write appears on `pins_oe` or `pins_out` on the next clock.

// File: rtl/parport_pkg.sv
package parport_pkg;
  localparam int unsigned BUS_W = 32;

  typedef enum logic [1:0] {
    PM_INPUT  = 2'd0,
    PM_OUTPUT = 2'd1,
    PM_BIDIR  = 2'd2
  } port_mode_e;

  typedef enum logic [1:0] {
    EK_RISE = 2'd0,
    EK_FALL = 2'd1,
    EK_ANY  = 2'd2
  } edge_kind_e;

  typedef enum logic [1:0] {
    RA_DATA = 2'd0,
    RA_DIR  = 2'd1,
    RA_MASK = 2'd2,
    RA_CAPT = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/parport_sync.sv
module parport_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= '0;
    else        chain_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/parport_capture.sv
module parport_capture
  import parport_pkg::*;
#(
  parameter int unsigned WIDTH     = 8,
  parameter edge_kind_e  EDGE      = EK_ANY,
  parameter bit          IRQ_LEVEL = 1'b0,
  parameter bit          HAS_IN    = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] clr,
  input  logic [WIDTH-1:0] mask,
  output logic [WIDTH-1:0] cap_q,
  output logic             irq
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] hit_raw;
  logic [WIDTH-1:0] hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  if (EDGE == EK_RISE) begin : g_rise
    assign hit_raw = level & ~prev_q;
  end else if (EDGE == EK_FALL) begin : g_fall
    assign hit_raw = ~level & prev_q;
  end else begin : g_any
    assign hit_raw = level ^ prev_q;
  end

  assign hit = HAS_IN ? hit_raw : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else        cap_q <= (cap_q & ~clr) | hit;
  end

  if (IRQ_LEVEL) begin : g_irq_level
    assign irq = |(level & mask);
  end else begin : g_irq_edge
    assign irq = |(cap_q & mask);
  end

  // R6
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(cap_q) & ~$past(clr) & ~cap_q) == '0));

  // R7
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(hit) & ~cap_q) == '0));
endmodule

// File: rtl/parport_top.sv
module parport_top
  import parport_pkg::*;
#(
  parameter int unsigned WIDTH     = 8,
  parameter port_mode_e  MODE      = PM_BIDIR,
  parameter edge_kind_e  EDGE      = EK_ANY,
  parameter bit          IRQ_LEVEL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [WIDTH-1:0] pins_in,
  output logic [WIDTH-1:0] pins_out,
  output logic [WIDTH-1:0] pins_oe,
  output logic             irq
);
  localparam bit HAS_IN   = (MODE != PM_OUTPUT);
  localparam bit HAS_OUT  = (MODE != PM_INPUT);
  localparam bit IS_BIDIR = (MODE == PM_BIDIR);

  logic [WIDTH-1:0] data_q, dir_q, mask_q, cap_q, level, clr;
  logic [BUS_W-1:0] rdata_q, rd_mux;
  reg_addr_e        addr;
  logic             wr_data, wr_dir, wr_mask, wr_capt, rd_req;

  assign addr    = reg_addr_e'(bus_addr);
  assign wr_data = bus_sel & bus_wr & (addr == RA_DATA) & HAS_OUT;
  assign wr_dir  = bus_sel & bus_wr & (addr == RA_DIR) & IS_BIDIR;
  assign wr_mask = bus_sel & bus_wr & (addr == RA_MASK) & HAS_IN;
  assign wr_capt = bus_sel & bus_wr & (addr == RA_CAPT);
  assign rd_req  = bus_sel & ~bus_wr;
  assign clr     = wr_capt ? bus_wdata[WIDTH-1:0] : '0;

  function automatic logic [BUS_W-1:0] widen(input logic [WIDTH-1:0] v);
    logic [BUS_W-1:0] r;
    r = '0;
    r[WIDTH-1:0] = v;
    return r;
  endfunction

  parport_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pins_in), .sync_out(level)
  );

  parport_capture #(
    .WIDTH(WIDTH), .EDGE(EDGE), .IRQ_LEVEL(IRQ_LEVEL), .HAS_IN(HAS_IN)
  ) u_capture (
    .clk(clk), .rst_n(rst_n), .level(level), .clr(clr),
    .mask(mask_q), .cap_q(cap_q), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      mask_q <= '0;
    end else begin
      if (wr_data) data_q <= bus_wdata[WIDTH-1:0];
      if (wr_dir)  dir_q  <= bus_wdata[WIDTH-1:0];
      if (wr_mask) mask_q <= bus_wdata[WIDTH-1:0];
    end
  end

  always_comb begin
    unique case (addr)
      RA_DATA: rd_mux = HAS_IN   ? widen(level)  : '0;
      RA_DIR:  rd_mux = IS_BIDIR ? widen(dir_q)  : '0;
      RA_MASK: rd_mux = HAS_IN   ? widen(mask_q) : '0;
      default: rd_mux = HAS_IN   ? widen(cap_q)  : '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_req) rdata_q <= rd_mux;
  end
  assign bus_rdata = rdata_q;

  if (MODE == PM_BIDIR) begin : g_oe_bidir
    assign pins_oe = dir_q;
  end else if (MODE == PM_OUTPUT) begin : g_oe_out
    assign pins_oe = '1;
  end else begin : g_oe_in
    assign pins_oe = '0;
  end

  assign pins_out = HAS_OUT ? data_q : '0;

  // R3
  out_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pins_out == $past(pins_out)) || $past(wr_data)));

  // R4
  oe_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pins_oe == $past(pins_oe)) || $past(wr_dir)));

  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
endmodule

// File: tb/parport_top_test.sv
module parport_top_test;
  import parport_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata, rdata2;
  logic [7:0]  pins_in = '0, pins_out, pins_oe;
  logic [3:0]  out2, oe2;
  logic        irq, irq2;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  parport_top #(.WIDTH(8), .MODE(PM_BIDIR), .EDGE(EK_ANY), .IRQ_LEVEL(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata),
    .pins_in(pins_in), .pins_out(pins_out), .pins_oe(pins_oe), .irq(irq)
  );

  parport_top #(.WIDTH(4), .MODE(PM_INPUT), .EDGE(EK_RISE), .IRQ_LEVEL(1'b1)) uut_lvl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata2),
    .pins_in(pins_in[3:0]), .pins_out(out2), .pins_oe(oe2), .irq(irq2)
  );

  typedef struct packed { logic [7:0] in_v; logic [7:0] out_v; } vec_t;
  localparam vec_t VECS [6] = '{
    '{8'h00, 8'h3C}, '{8'h81, 8'hFF}, '{8'h81, 8'h00},
    '{8'h7E, 8'h55}, '{8'h0F, 8'hAA}, '{8'hF0, 8'h01}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic set_in(input logic [7:0] v);
    @(negedge clk);
    pins_in = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pins_out", {24'h0, pins_out}, 32'h0);
    chk("R1 pins_oe", {24'h0, pins_oe}, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    for (int a = 1; a < 4; a++) begin
      rd(2'(a));
      chk("R1 reg read", rdata, 32'h0);
    end

    // R2 R3 R4 R5 table walk
    prev = 8'h00;
    for (int i = 0; i < 6; i++) begin
      wr(2'd0, {24'h0, VECS[i].out_v});
      set_in(VECS[i].in_v);
      chk("R3 pins_out", {24'h0, pins_out}, {24'h0, VECS[i].out_v});
      chk("R4 input-only out", {28'h0, out2}, 32'h0);
      chk("R4 input-only oe", {28'h0, oe2}, 32'h0);
      rd(2'd0);
      chk("R2 R3 data read", rdata, {24'h0, VECS[i].in_v});
      chk("R2 narrow read", rdata2, {28'h0, VECS[i].in_v[3:0]});
      rd(2'd3);
      chk("R5 any-edge capture", rdata, {24'h0, prev ^ VECS[i].in_v});
      chk("R5 rise-only capture", rdata2, {28'h0, VECS[i].in_v[3:0] & ~prev[3:0]});
      wr(2'd3, 32'hFFFF_FFFF);
      prev = VECS[i].in_v;
    end

    // R4 R10 R11 direction
    wr(2'd1, 32'hFFFF_FF5A);
    chk("R4 oe from direction", {24'h0, pins_oe}, 32'h5A);
    rd(2'd1);
    chk("R11 direction upper zero", rdata, 32'h5A);
    chk("R10 unimplemented direction", rdata2, 32'h0);
    wr(2'd1, 32'h0);
    chk("R4 oe cleared", {24'h0, pins_oe}, 32'h0);

    // R8 R9 R6 interrupt and sticky clear
    wr(2'd2, 32'h13);
    rd(2'd2);
    chk("R11 mask read", rdata, 32'h13);
    chk("R11 narrow mask read", rdata2, 32'h3);
    chk("R8 irq idle", {31'h0, irq}, 32'h0);
    set_in(8'hF1);
    chk("R8 irq on masked capture", {31'h0, irq}, 32'h1);
    chk("R9 level irq high", {31'h0, irq2}, 32'h1);
    set_in(8'hF0);
    chk("R8 irq held by sticky bit", {31'h0, irq}, 32'h1);
    chk("R9 level irq low", {31'h0, irq2}, 32'h0);
    rd(2'd3);
    chk("R5 rise-only ignores fall", rdata2, 32'h1);
    wr(2'd2, 32'h0);
    chk("R8 irq masked off", {31'h0, irq}, 32'h0);
    wr(2'd3, 32'h0);
    rd(2'd3);
    chk("R6 write zero keeps bit", rdata, 32'h1);
    wr(2'd3, 32'h1);
    rd(2'd3);
    chk("R6 write one clears", rdata, 32'h0);
    wr(2'd3, 32'hFF);

    // R7 coincident clear and edge
    set_in(8'hF4);
    @(negedge clk);
    pins_in = 8'hF0;
    @(negedge clk);
    wr(2'd3, 32'h4);
    rd(2'd3);
    chk("R7 edge beats clear", rdata, 32'h4);
    chk("R7 rise-only build clears", rdata2, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule